// File: doc/BRIEF.md
# I2S Serial Audio Transmit Framer

This block turns parallel audio words into the serial data stream of an I2S link. The bit clock and the word-select line come from outside and are sampled with the block's own system clock. Each change of word select opens a slot for one channel, 0 for left and 1 for right. One bit clock after that change, the block starts to send the sample for the slot, most significant bit first. It drives each new bit after a falling bit-clock edge, so that a receiver can sample on the rising edge.

Audio words come in over a valid/ready handshake. A set of static configuration inputs controls the transfer. It selects one of eight sample formats, two of which pack a left/right pair into one word. It can copy the left sample into the right slot, and it decides what goes out when no word is ready at a slot start: zeros, or the last sample of that channel. A sticky flag records any slot filled in this way. A half-frame length output tells the clock source how many bit clocks each word-select half needs. A loopback switch routes the serial output onto the receive-side data line for self-test.

Top module: `i2s_tx_framer`

## Requirements
- R1: The 3-bit format code gives the sample length: 0 is 32 bits, 1 is 24, 2 is 20, 3 is 18, 4 and 5 are 16, and 6 and 7 are 8. A sample is the low bits of the input word, and each slot sends exactly that many bits.
- R2: The first bit of a slot is the sample's most significant bit. It is sent in the bit clock after the word-select change. The following bits go out one per bit clock, and zeros fill the slot after the last bit. The serial output changes only after a falling bit-clock edge.
- R3: Codes 5 and 7 are packed formats. One word serves a whole frame: the left sample is in the low half (bits 15:0 or 7:0) and the right sample sits in the bits just above it (31:16 or 15:8). The right slot consumes no word.
- R4: `half_len_o` reads 24 when `slot24_i` is 1 and the code is 1, 2 or 3. In every other case it reads 32.
- R5: When `mono_i` is 1, the right slot repeats the sample sent in the preceding left slot and consumes no word.
- R6: When a slot needs a word, no word is valid and `repeat_i` is 0, the slot sends zeros. In a packed format, both channels get zeros.
- R7: When a slot needs a word, no word is valid and `repeat_i` is 1, the slot resends that channel's last sample. In a packed format, both channels resend their last samples.
- R8: `urun_o` goes to 1 after any slot filled under R6 or R7. It holds until a cycle with `urun_clr_i` high and no new fill.
- R9: `rx_sd_o` equals `sd_o` when `loop_i` is 1 and equals `rx_sd_i` when `loop_i` is 0.
- R10: After reset, `sd_o`, `s_ready` and `urun_o` are 0. The block treats the word-select line as being in the right half, so the first falling edge of word select opens a left slot.
- R11: `s_ready` is a one-cycle pulse at a slot start that needs a word. Exactly one word is taken per left slot, plus one per right slot in the unpacked stereo formats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bck_i | input | 1 | External bit clock |
| ws_i | input | 1 | External word select, 0 left, 1 right |
| fmt_i | input | 3 | Sample format code |
| mono_i | input | 1 | Copy left sample into right slot |
| repeat_i | input | 1 | Underrun policy: 0 zeros, 1 last sample |
| slot24_i | input | 1 | 24-clock halves for 18/20/24-bit formats |
| loop_i | input | 1 | Route serial output to receive line |
| s_valid | input | 1 | Input word valid |
| s_data | input | 32 | Input audio word |
| s_ready | output | 1 | Word taken this cycle |
| sd_o | output | 1 | Serial data out |
| rx_sd_i | input | 1 | External serial data for the receive path |
| rx_sd_o | output | 1 | Serial data to the receive path |
| urun_clr_i | input | 1 | Clear the underrun flag |
| urun_o | output | 1 | Sticky underrun flag |
| half_len_o | output | 6 | Bit clocks per word-select half |

## Verification
The table runs every format code at least once, each with words that have different patterns in the top and bottom bits. This separates a wrong length, a wrong bit order, a shifted slot start and missing zero padding. The packed rows use words with distinct halves, which exposes swapped or misplaced channels. Mono rows give left and right different content, so a missed copy shows up. Rows with fewer words than slots separate zero fill from repeat fill, per channel and for packed pairs. Each row also compares the number of handshakes with the model and tests the sticky flag before and after a clear. The loopback rows toggle the external receive input so that the output must follow one source or the other.

// File: rtl/i2s_tx_pkg.sv
`timescale 1ns/1ps
// Shared types and format decoding for the I2S transmit framer.
package i2s_tx_pkg;
    localparam int WORD_W      = 32;
    localparam int LEN_W       = $clog2(WORD_W + 1);
    localparam int SLOT_WIDE   = 32;
    localparam int SLOT_NARROW = 24;

    typedef enum logic [2:0] {
        FMT_32      = 3'd0,
        FMT_24      = 3'd1,
        FMT_20      = 3'd2,
        FMT_18      = 3'd3,
        FMT_16      = 3'd4,
        FMT_16_PAIR = 3'd5,
        FMT_8       = 3'd6,
        FMT_8_PAIR  = 3'd7
    } fmt_e;

    // Sample length in bits for a format code.
    function automatic logic [LEN_W-1:0] fmt_bits(fmt_e f);
        case (f)
            FMT_32:               return LEN_W'(32);
            FMT_24:               return LEN_W'(24);
            FMT_20:               return LEN_W'(20);
            FMT_18:               return LEN_W'(18);
            FMT_16, FMT_16_PAIR:  return LEN_W'(16);
            default:              return LEN_W'(8);
        endcase
    endfunction

    // True for the formats that carry a left/right pair in one word.
    function automatic logic fmt_packed(fmt_e f);
        return (f == FMT_16_PAIR) || (f == FMT_8_PAIR);
    endfunction

    // True for the formats whose slot may be narrowed to 24 clocks.
    function automatic logic fmt_narrowable(fmt_e f);
        return (f == FMT_24) || (f == FMT_20) || (f == FMT_18);
    endfunction
endpackage

// File: rtl/i2s_tx_edge.sv
`timescale 1ns/1ps
// Bit-clock and word-select front end.
// Brings the external bit clock and word select into the system clock
// domain, finds their rising and falling edges, and flags the start of
// a channel slot when word select has changed at a rising bit-clock edge.
// Assumes the system clock is at least four times the bit clock and that
// word select only moves near falling bit-clock edges.
module i2s_tx_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bck_i,
    input  logic ws_i,
    output logic bck_fall,
    output logic slot_start,
    output logic slot_right
);
    logic [SYNC_STAGES-1:0] bck_pipe;
    logic [SYNC_STAGES-1:0] ws_pipe;
    logic bck_s, ws_s, bck_d, ws_last, bck_rise;

    // Synchronizer chains for both external lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bck_pipe <= '0;
            ws_pipe  <= '1;
        end else begin
            bck_pipe <= {bck_pipe[SYNC_STAGES-2:0], bck_i};
            ws_pipe  <= {ws_pipe[SYNC_STAGES-2:0], ws_i};
        end
    end

    assign bck_s = bck_pipe[SYNC_STAGES-1];
    assign ws_s  = ws_pipe[SYNC_STAGES-1];

    // Previous bit-clock level and word select as seen at the last rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bck_d   <= 1'b0;
            ws_last <= 1'b1;
        end else begin
            bck_d <= bck_s;
            if (bck_rise) ws_last <= ws_s;
        end
    end

    assign bck_rise   = bck_s & ~bck_d;
    assign bck_fall   = ~bck_s & bck_d;
    assign slot_start = bck_rise & (ws_s != ws_last);
    assign slot_right = ws_s;
endmodule

// File: rtl/i2s_tx_select.sv
`timescale 1ns/1ps
// Sample selection for each slot.
// At a slot start, decides whether a new word is needed, takes it when
// valid, or fills the slot from the underrun policy, applies packed-pair
// and mono rules, and presents the sample left-aligned for shifting.
// Assumes configuration inputs are static while slots run.
module i2s_tx_select
    import i2s_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_start,
    input  logic              slot_right,
    input  logic [2:0]        fmt_code,
    input  logic              mono,
    input  logic              repeat_last,
    input  logic              s_valid,
    input  logic [WORD_W-1:0] s_data,
    output logic              s_ready,
    output logic [WORD_W-1:0] slot_word,
    output logic              fill_evt
);
    fmt_e              fmt;
    logic [LEN_W-1:0]  len;
    logic              pk;
    logic [WORD_W-1:0] mask, in_lo, in_hi;
    logic [WORD_W-1:0] last_l, last_r, cur, pair_r;
    logic              need, take;

    assign fmt   = fmt_e'(fmt_code);
    assign len   = fmt_bits(fmt);
    assign pk    = fmt_packed(fmt);
    assign mask  = ~({WORD_W{1'b1}} << len);
    assign in_lo = s_data & mask;
    assign in_hi = (s_data >> len) & mask;

    assign need     = slot_start & (~slot_right | (~mono & ~pk));
    assign take     = need & s_valid;
    assign fill_evt = need & ~s_valid;
    assign s_ready  = need;

    // Choose the sample for the slot that is starting.
    always_comb begin
        cur    = '0;
        pair_r = '0;
        if (!slot_right) begin
            cur    = take ? in_lo : (repeat_last ? last_l : '0);
            pair_r = take ? in_hi : (repeat_last ? last_r : '0);
        end else if (mono) begin
            cur = last_l;
        end else if (pk) begin
            cur = last_r;
        end else begin
            cur = take ? in_lo : (repeat_last ? last_r : '0);
        end
    end

    assign slot_word = cur << (LEN_W'(WORD_W) - len);

    // Remember the last sample sent per channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_l <= '0;
            last_r <= '0;
        end else if (slot_start) begin
            if (!slot_right) begin
                last_l <= cur;
                if (pk) last_r <= pair_r;
            end else begin
                last_r <= cur;
            end
        end
    end

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready); // R11
endmodule

// File: rtl/i2s_tx_shift.sv
`timescale 1ns/1ps
// Output shift register.
// Loads a left-aligned slot word at a slot start and moves one bit to the
// serial output at every falling bit-clock edge, filling with zeros.
// Assumes load and falling edge never fall in the same cycle.
module i2s_tx_shift
    import i2s_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              sd_o
);
    logic [WORD_W-1:0] shreg;

    // Load on slot start, emit and advance on falling bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            sd_o  <= 1'b0;
        end else if (load_i) begin
            shreg <= word_i;
        end else if (shift_i) begin
            sd_o  <= shreg[WORD_W-1];
            shreg <= {shreg[WORD_W-2:0], 1'b0};
        end
    end

    AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd_o) |-> $past(shift_i)); // R2
endmodule

// File: rtl/i2s_tx_framer.sv
`timescale 1ns/1ps
// I2S transmit framer top.
// Joins the edge front end, sample selection and shifter, keeps the
// sticky underrun flag, reports the half-frame length and provides the
// loopback route to the receive path. Configuration inputs are static.
module i2s_tx_framer
    import i2s_tx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bck_i,
    input  logic              ws_i,
    input  logic [2:0]        fmt_i,
    input  logic              mono_i,
    input  logic              repeat_i,
    input  logic              slot24_i,
    input  logic              loop_i,
    input  logic              s_valid,
    input  logic [WORD_W-1:0] s_data,
    output logic              s_ready,
    output logic              sd_o,
    input  logic              rx_sd_i,
    output logic              rx_sd_o,
    input  logic              urun_clr_i,
    output logic              urun_o,
    output logic [LEN_W-1:0]  half_len_o
);
    logic              bck_fall, slot_start, slot_right, fill_evt;
    logic [WORD_W-1:0] slot_word;

    i2s_tx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .bck_i      (bck_i),
        .ws_i       (ws_i),
        .bck_fall   (bck_fall),
        .slot_start (slot_start),
        .slot_right (slot_right)
    );

    i2s_tx_select u_select (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_start  (slot_start),
        .slot_right  (slot_right),
        .fmt_code    (fmt_i),
        .mono        (mono_i),
        .repeat_last (repeat_i),
        .s_valid     (s_valid),
        .s_data      (s_data),
        .s_ready     (s_ready),
        .slot_word   (slot_word),
        .fill_evt    (fill_evt)
    );

    i2s_tx_shift u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (slot_start),
        .shift_i (bck_fall),
        .word_i  (slot_word),
        .sd_o    (sd_o)
    );

    // Sticky underrun flag; a new fill wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          urun_o <= 1'b0;
        else if (fill_evt)   urun_o <= 1'b1;
        else if (urun_clr_i) urun_o <= 1'b0;
    end

    assign half_len_o = (slot24_i && fmt_narrowable(fmt_e'(fmt_i))) ?
                        LEN_W'(SLOT_NARROW) : LEN_W'(SLOT_WIDE);
    assign rx_sd_o    = loop_i ? sd_o : rx_sd_i;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        fill_evt |=> urun_o); // R8
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (urun_o && !urun_clr_i) |=> urun_o); // R8
    AST_READY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> slot_start); // R11
endmodule

// File: tb/test_i2s_tx_framer.sv
`timescale 1ns/1ps
module test_i2s_tx_framer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bck = 1'b1, ws = 1'b1;
    logic [2:0]  fmt = 3'd0;
    logic        mono = 1'b0, rep = 1'b0, s24 = 1'b0, loop_en = 1'b0;
    logic        rx_in = 1'b0, clr = 1'b0;
    logic        s_valid = 1'b0;
    logic [31:0] s_data = '0;
    logic        s_ready, sd, rx_out, urun;
    logic [5:0]  half_len;

    int n_run = 0, n_fail = 0, idx = 0;

    typedef struct packed {
        logic [2:0]        code;
        logic              mono;
        logic              rep;
        logic              s24;
        logic              lp;
        logic [2:0]        nw;
        logic [3:0][31:0]  w;
    } row_t;

    localparam int NROWS = 12;
    localparam row_t ROWS [NROWS] = '{
        '{3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4, {32'hFFFF0000, 32'h80000001, 32'h12345678, 32'hA5C30F1E}},
        '{3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4, {32'h00800001, 32'hFFC35A81, 32'h00F0F00F, 32'h00ABCDEF}},
        '{3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4, {32'h000C0003, 32'hFFF80001, 32'h00012345, 32'h0008FFFE}},
        '{3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4, {32'h00020001, 32'h0003FFFF, 32'h00015555, 32'h0002AAAA}},
        '{3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4, {32'h00008001, 32'h0000FFFE, 32'hDEAD1234, 32'h0000C3A5}},
        '{3'd5, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, {32'h0, 32'h0, 32'h00018000, 32'hBEEF1234}},
        '{3'd6, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2, {32'h0, 32'h0, 32'h00000081, 32'h000000C5}},
        '{3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, {32'h0, 32'h0, 32'h000080FE, 32'h00003CA1}},
        '{3'd4, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1, {32'h0, 32'h0, 32'h0, 32'h0000B00F}},
        '{3'd4, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2, {32'h0, 32'h0, 32'h0000700E, 32'h0000A001}},
        '{3'd5, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, {32'h0, 32'h0, 32'h0, 32'h5A5A81C3}},
        '{3'd1, 1'b1, 1'b1, 1'b0, 1'b1, 3'd1, {32'h0, 32'h0, 32'h0, 32'h00C00003}}
    };

    row_t cur;

    i2s_tx_framer i_i2s_tx_framer (
        .clk(clk), .rst_n(rst_n), .bck_i(bck), .ws_i(ws), .fmt_i(fmt),
        .mono_i(mono), .repeat_i(rep), .slot24_i(s24), .loop_i(loop_en),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .sd_o(sd),
        .rx_sd_i(rx_in), .rx_sd_o(rx_out), .urun_clr_i(clr), .urun_o(urun),
        .half_len_o(half_len)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic present_word();
        s_valid = (idx < int'(cur.nw));
        s_data  = (idx < int'(cur.nw)) ? cur.w[idx] : 32'h0;
    endtask

    // One system clock; advance the word list after a handshake.
    task automatic step();
        bit fire;
        fire = s_valid && s_ready;
        @(posedge clk);
        #1;
        if (fire) begin
            idx++;
            present_word();
        end
    endtask

    function automatic int blen(input logic [2:0] c);
        case (c)
            3'd0: return 32;
            3'd1: return 24;
            3'd2: return 20;
            3'd3: return 18;
            3'd4, 3'd5: return 16;
            default: return 8;
        endcase
    endfunction

    function automatic logic [31:0] lowbits(input logic [31:0] v, input int n);
        logic [63:0] m;
        m = (64'd1 << n) - 64'd1;
        return v & m[31:0];
    endfunction

    // Drive one word-select half and compare the serial stream.
    task automatic run_half(input bit right, input logic [31:0] smp, input int len, input int hl,
                            inout logic prev_last, inout int bad, inout int lbad);
        logic exp_b;
        for (int k = 0; k < hl; k++) begin
            bck = 1'b0;
            if (k == 0) ws = right;
            repeat (6) step();
            if (k == 0) exp_b = prev_last;
            else exp_b = (k <= len) ? smp[len-k] : 1'b0;
            if (sd !== exp_b) bad++;
            if (loop_en ? (rx_out !== sd) : (rx_out !== rx_in)) lbad++;
            rx_in = ~rx_in;
            bck = 1'b1;
            repeat (6) step();
        end
        prev_last = (hl <= len) ? smp[len-hl] : 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bck = 1'b1; ws = 1'b1; clr = 1'b0;
        repeat (4) step();
        rst_n = 1'b1;
        repeat (2) step();
    endtask

    task automatic run_row(input int r);
        int len, hl, used, bad, lbad;
        bit pk, mflag, avail;
        logic [31:0] last_l, last_r, l, rr, wv;
        logic prev_last;
        string tag;
        cur = ROWS[r];
        fmt = cur.code; mono = cur.mono; rep = cur.rep; s24 = cur.s24; loop_en = cur.lp;
        idx = 0;
        present_word();
        do_reset();
        len = blen(cur.code);
        pk = (cur.code == 3'd5) || (cur.code == 3'd7);
        hl = (cur.s24 && cur.code >= 3'd1 && cur.code <= 3'd3) ? 24 : 32;
        check(half_len == 6'(hl), $sformatf("R4 row%0d half length", r), half_len, hl);
        used = 0; mflag = 0; last_l = 0; last_r = 0; prev_last = 1'b0; lbad = 0;
        tag = pk ? "R3" : (cur.mono ? "R5" : (int'(cur.nw) < 4 ? (cur.rep ? "R7" : "R6") : "R1"));
        for (int f = 0; f < 2; f++) begin
            // left slot model
            avail = used < int'(cur.nw);
            wv = avail ? cur.w[used] : 32'h0;
            if (avail) begin
                l = lowbits(wv, len);
                rr = pk ? lowbits(wv >> len, len) : last_r;
                used++;
            end else begin
                mflag = 1;
                l = cur.rep ? last_l : 32'h0;
                rr = cur.rep ? last_r : 32'h0;
            end
            last_l = l;
            if (pk) last_r = rr;
            bad = 0;
            run_half(1'b0, l, len, hl, prev_last, bad, lbad);
            check(bad == 0, $sformatf("%s R2 row%0d frame%0d left slot bit errors", tag, r, f), bad, 0);
            // right slot model
            if (cur.mono) rr = last_l;
            else if (pk) rr = last_r;
            else begin
                avail = used < int'(cur.nw);
                if (avail) begin
                    rr = lowbits(cur.w[used], len);
                    used++;
                end else begin
                    mflag = 1;
                    rr = cur.rep ? last_r : 32'h0;
                end
            end
            last_r = rr;
            bad = 0;
            run_half(1'b1, rr, len, hl, prev_last, bad, lbad);
            check(bad == 0, $sformatf("%s R2 row%0d frame%0d right slot bit errors", tag, r, f), bad, 0);
        end
        check(urun == mflag, $sformatf("R8 row%0d underrun flag", r), urun, mflag);
        check(idx == used, $sformatf("R11 row%0d words taken", r), idx, used);
        check(lbad == 0, $sformatf("R9 row%0d receive route mismatches", r), lbad, 0);
        if (mflag) begin
            clr = 1'b1;
            step();
            clr = 1'b0;
            step();
            check(urun == 1'b0, $sformatf("R8 row%0d flag after clear", r), urun, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        cur = ROWS[0];
        do_reset();
        // R10 reset state
        check(sd == 1'b0, "R10 serial output after reset", sd, 0);
        check(s_ready == 1'b0, "R10 ready after reset", s_ready, 0);
        check(urun == 1'b0, "R10 flag after reset", urun, 0);
        // R9 directed routing
        loop_en = 1'b0; rx_in = 1'b1; step();
        check(rx_out == 1'b1, "R9 external input routed", rx_out, 1);
        rx_in = 1'b0; step();
        check(rx_out == 1'b0, "R9 external input routed low", rx_out, 0);
        loop_en = 1'b1; rx_in = 1'b1; step();
        check(rx_out == sd, "R9 loopback ignores external input", rx_out, sd);
        // table walk
        for (int r = 0; r < NROWS; r++) run_row(r);
        // R4 directed: narrow slot ignored for 16-bit format
        fmt = 3'd4; s24 = 1'b1; step();
        check(half_len == 6'd32, "R4 slot24 ignored for 16-bit", half_len, 32);
        fmt = 3'd0; step();
        check(half_len == 6'd32, "R4 slot24 ignored for 32-bit", half_len, 32);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule